// File: doc/BRIEF.md
# Double-Buffered Serial Gain and Bias Control Port

This block is the digital control port of a programmable variable-gain amplifier. A host writes 12-bit command words over a three-wire serial bus made of a serial clock, serial data and an active-low select. Each accepted word updates a pending (shadow) copy of the gain and bias-current settings. The amplifier itself only ever sees an active copy, and that copy is loaded from the pending copy on a rising edge of the transmit-enable input. A host can therefore prepare the next burst's settings at any time, including mid-burst, without disturbing the burst in progress.

The serial lines and transmit-enable are asynchronous to the system clock. They pass through two-flop synchronizers, and their edges are detected in the system clock domain. The serial clock must therefore stay in each level for at least three system clock cycles. From the active settings the block derives a clamped gain step index and an effective bias tier, which steps the programmed bias down automatically at lower gains. The block has no stream data path. All pins are plain level controls with no valid/ready handshake or back-pressure, because a command either lands in the pending register or is dropped.

Top module: `vga_ctl_port`

## Requirements
- R1: After asynchronous reset, gain_code_o is 63, cur_code_o is 3, gain_idx_o is 58, bias_tier_o is 3 and amp_en_o is 0.
- R2: A word is shifted in on rising serial-clock edges while ser_sel_ni is low, MSB first. It is taken when ser_sel_ni returns high. Bits 11..8 are the address, bits 7..6 the current code and bits 5..0 the gain code.
- R3: Address 0 copies the word's current and gain codes into the pending register. Address 1 sets the pending register to gain code 0 and current code 0.
- R4: A word with any address from 2 to 15 changes no state. A following transmit-enable rise still applies the previous pending values.
- R5: gain_code_o and cur_code_o change only on a transmit-enable rising edge. A word written while transmit-enable is high stays pending until the next rise.
- R6: A transmit-enable rise with no write since the last one reapplies the same active settings.
- R7: gain_idx_o is 0 for gain codes 0 to 5, and gain code minus 5 for codes 6 to 63.
- R8: bias_tier_o equals cur_code_o for gain codes 55–63. It is cur_code_o−1 for 49–54 and cur_code_o−2 for 40–48, each floored at 0. It is 0 for gain codes 0–39.
- R9: amp_en_o follows transmit-enable after synchronization. Words written while transmit-enable is low are still accepted into the pending register.
- R10: A select rise after a bit count other than 12 discards the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bus clock, asynchronous |
| ser_dat_i | input | 1 | Serial bus data, MSB first |
| ser_sel_ni | input | 1 | Serial bus select, active low |
| tx_en_i | input | 1 | Transmit enable, asynchronous |
| gain_code_o | output | 6 | Active gain code |
| gain_idx_o | output | 6 | Clamped gain step index |
| cur_code_o | output | 2 | Active bias-current code |
| bias_tier_o | output | 2 | Gain-dependent effective bias tier |
| amp_en_o | output | 1 | Amplifier enable |

## Verification
A corrupt pending register cannot be seen while it is wrong. It shows at the outputs only on the next transmit-enable rise, about three system cycles after tx_en_i rises. For that reason every write in the bench is followed by a transmit-enable pulse before the outputs are compared. A wrong shift count or address decode surfaces the same way: the settings applied at the next rise are not the ones expected. A fault in the derived index or bias tier shows combinationally, in the same cycle as the active code. The full sweep over all 256 gain and current pairs therefore exposes it at once.

// File: rtl/vga_ctl_pkg.sv
package vga_ctl_pkg;
  parameter int GAIN_W   = 6;
  parameter int CUR_W    = 2;
  parameter int ADDR_W   = 4;
  parameter int WORD_W   = ADDR_W + CUR_W + GAIN_W;
  parameter int MIN_CODE = 5;   // codes at or below share the lowest step
  parameter int FULL_TH  = 55;  // full programmed bias from here up
  parameter int MID_TH   = 49;  // one tier lower from here up
  parameter int LOW_TH   = 40;  // two tiers lower from here up
  parameter logic [ADDR_W-1:0] ADDR_SET  = 4'd0;
  parameter logic [ADDR_W-1:0] ADDR_INIT = 4'd1;

  typedef struct packed {
    logic [CUR_W-1:0]  cur;
    logic [GAIN_W-1:0] gain;
  } vga_cfg_t;

  localparam vga_cfg_t CFG_RESET = '{cur: '1, gain: '1};
  localparam vga_cfg_t CFG_INIT  = '{cur: '0, gain: '0};
endpackage

// File: rtl/vga_ctl_sync.sv
module vga_ctl_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d_i[i];
        s2 <= s1;
      end
    end
    assign q_o[i] = s2;
  end
endmodule

// File: rtl/vga_ctl_shifter.sv
module vga_ctl_shifter
  import vga_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              ssel_ni,
  output logic              word_vld_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             sclk_q, ssel_q;
  logic [CNT_W-1:0] cnt;
  logic             sclk_rise, ssel_rise;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign ssel_rise = ssel_ni & ~ssel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      ssel_q     <= 1'b1;
      cnt        <= '0;
      word_o     <= '0;
      word_vld_o <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      ssel_q     <= ssel_ni;
      word_vld_o <= 1'b0;
      if (ssel_rise) begin
        word_vld_o <= (cnt == CNT_W'(WORD_W));
        cnt        <= '0;
      end else if (!ssel_ni && sclk_rise) begin
        word_o <= {word_o[WORD_W-2:0], sdat_i};
        if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vga_ctl_regbank.sv
module vga_ctl_regbank
  import vga_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              word_vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              tx_i,
  output vga_cfg_t          act_o,
  output logic              amp_en_o
);
  logic [ADDR_W-1:0] addr;
  vga_cfg_t          wr_cfg, pend;
  logic              tx_q;

  assign addr   = word_i[WORD_W-1 -: ADDR_W];
  assign wr_cfg = vga_cfg_t'(word_i[CUR_W+GAIN_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend  <= CFG_RESET;
      act_o <= CFG_RESET;
      tx_q  <= 1'b0;
    end else begin
      tx_q <= tx_i;
      if (tx_i && !tx_q) act_o <= pend;
      if (word_vld_i) begin
        if (addr == ADDR_SET)       pend <= wr_cfg;
        else if (addr == ADDR_INIT) pend <= CFG_INIT;
      end
    end
  end

  assign amp_en_o = tx_q;
endmodule

// File: rtl/vga_ctl_map.sv
module vga_ctl_map
  import vga_ctl_pkg::*;
(
  input  vga_cfg_t           cfg_i,
  output logic [GAIN_W-1:0]  idx_o,
  output logic [CUR_W-1:0]   tier_o
);
  localparam logic [CUR_W-1:0] DROP_ALL = '1;
  logic [CUR_W-1:0] drop;

  always_comb begin
    if (cfg_i.gain <= GAIN_W'(MIN_CODE)) idx_o = '0;
    else                                  idx_o = cfg_i.gain - GAIN_W'(MIN_CODE);

    if (cfg_i.gain >= GAIN_W'(FULL_TH))     drop = CUR_W'(0);
    else if (cfg_i.gain >= GAIN_W'(MID_TH)) drop = CUR_W'(1);
    else if (cfg_i.gain >= GAIN_W'(LOW_TH)) drop = CUR_W'(2);
    else                                    drop = DROP_ALL;

    tier_o = (cfg_i.cur > drop) ? cfg_i.cur - drop : '0;
  end
endmodule

// File: rtl/vga_ctl_port.sv
module vga_ctl_port
  import vga_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  input  logic              ser_sel_ni,
  input  logic              tx_en_i,
  output logic [GAIN_W-1:0] gain_code_o,
  output logic [GAIN_W-1:0] gain_idx_o,
  output logic [CUR_W-1:0]  cur_code_o,
  output logic [CUR_W-1:0]  bias_tier_o,
  output logic              amp_en_o
);
  logic [3:0]        sync_q;
  logic              word_vld;
  logic [WORD_W-1:0] word;
  vga_cfg_t          act;

  // bit order: tx, sel, dat, clk; select idles high
  vga_ctl_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({tx_en_i, ser_sel_ni, ser_dat_i, ser_clk_i}),
    .q_o   (sync_q)
  );

  vga_ctl_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sync_q[0]),
    .sdat_i    (sync_q[1]),
    .ssel_ni   (sync_q[2]),
    .word_vld_o(word_vld),
    .word_o    (word)
  );

  vga_ctl_regbank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_vld_i(word_vld),
    .word_i    (word),
    .tx_i      (sync_q[3]),
    .act_o     (act),
    .amp_en_o  (amp_en_o)
  );

  vga_ctl_map u_map (
    .cfg_i (act),
    .idx_o (gain_idx_o),
    .tier_o(bias_tier_o)
  );

  assign gain_code_o = act.gain;
  assign cur_code_o  = act.cur;
endmodule

// File: rtl/vga_ctl_port_chk.sv
module vga_ctl_port_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] gain_code_o,
  input logic [5:0] gain_idx_o,
  input logic [1:0] cur_code_o,
  input logic [1:0] bias_tier_o,
  input logic       amp_en_o
);
  AST_HOLD_UNTIL_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(amp_en_o) |-> $stable({gain_code_o, cur_code_o})); // R5
  AST_LOW_CODES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_o <= 6'd5) |-> (gain_idx_o == 6'd0)); // R7
  AST_TIER_CAPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bias_tier_o <= cur_code_o); // R8
  AST_TIER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_o >= 6'd55) |-> (bias_tier_o == cur_code_o)); // R8
  AST_TIER_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gain_code_o < 6'd40) |-> (bias_tier_o == 2'd0)); // R8
endmodule

bind vga_ctl_port vga_ctl_port_chk u_chk (.*);

// File: tb/vga_ctl_port_bench.sv
`timescale 1ns/1ps
module vga_ctl_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, ssel_n = 1'b1, tx = 1'b0;
  logic [5:0] gcode, gidx;
  logic [1:0] ccode, tier;
  logic       en;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vga_ctl_port u_vga_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .ser_sel_ni(ssel_n), .tx_en_i(tx), .gain_code_o(gcode),
    .gain_idx_o(gidx), .cur_code_o(ccode), .bias_tier_o(tier),
    .amp_en_o(en)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_idx(int g);
    return (g <= 5) ? 0 : g - 5;
  endfunction

  function automatic int exp_tier(int g, int c);
    int d;
    d = (g >= 55) ? 0 : (g >= 49) ? 1 : (g >= 40) ? 2 : 3;
    return (c > d) ? c - d : 0;
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bits(logic [15:0] w, int nbits);
    @(negedge clk); ssel_n = 1'b0; wait_clk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      @(negedge clk); sdat = w[i]; wait_clk(4);
      @(negedge clk); sclk = 1'b1; wait_clk(4);
      @(negedge clk); sclk = 1'b0;
    end
    wait_clk(4);
    @(negedge clk); ssel_n = 1'b1; wait_clk(8);
  endtask

  task automatic tx_rise();
    @(negedge clk); tx = 1'b0; wait_clk(6);
    @(negedge clk); tx = 1'b1; wait_clk(6);
    @(negedge clk);
  endtask

  task automatic check_out(string req, int g, int c);
    chk(req, gcode, g);
    chk(req, ccode, c);
    chk({req, " idx R7"}, gidx, exp_idx(g));
    chk({req, " tier R8"}, tier, exp_tier(g, c));
  endtask

  initial begin
    fork
      begin : watchdog
        wait_clk(190000);
        if (!done) begin
          n_bad++; n_cmp++;
          $display("FAIL watchdog actual=timeout expected=done");
          $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
          $finish;
        end
      end
    join_none

    wait_clk(3);
    @(negedge clk);
    // R1 reset state
    check_out("R1", 63, 3);
    chk("R1 en", en, 0);
    rst_n = 1'b1;
    wait_clk(4); @(negedge clk);
    check_out("R1", 63, 3);

    // R2 R3 R7 R8: full sweep via address 0, writes while tx low (R9)
    for (int c = 0; c < 4; c++) begin
      for (int g = 0; g < 64; g++) begin
        @(negedge clk); tx = 1'b0; wait_clk(6);
        @(negedge clk);
        chk("R9 en low", en, 0);
        send_bits({4'd0, 4'd0, c[1:0], g[5:0]}, 12);
        @(negedge clk); tx = 1'b1; wait_clk(6); @(negedge clk);
        chk("R9 en high", en, 1);
        check_out("R2 R3 sweep", g, c);
      end
    end

    // R5: write while enabled stays pending
    send_bits({4'd0, 4'd0, 2'd2, 6'd50}, 12);
    check_out("R5 held", 63, 3);
    tx_rise();
    check_out("R5 applied", 50, 2);

    // R6: rise without write reapplies
    tx_rise();
    check_out("R6 reapply", 50, 2);

    // R4: addresses 2..15 ignored
    for (int a = 2; a < 16; a++) begin
      send_bits({4'd0, a[3:0], 2'd0, 6'd9}, 12);
      tx_rise();
      check_out("R4 ignored addr", 50, 2);
    end

    // R10: wrong bit counts discarded
    send_bits({5'd0, 4'd0, 2'd1, 6'd20}, 11);
    tx_rise();
    check_out("R10 short word", 50, 2);
    send_bits({3'd0, 1'b0, 4'd0, 2'd1, 6'd20}, 13);
    tx_rise();
    check_out("R10 long word", 50, 2);

    // R3: initialize address clears pending
    send_bits({4'd0, 4'd1, 2'd3, 6'd33}, 12);
    check_out("R3 init pending", 50, 2);
    tx_rise();
    check_out("R3 init applied", 0, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule